// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block is a small direct-mapped cache between a processor port and a backing memory port. It holds 32 bytes of data as four lines of 8 bytes, each line with a valid bit and a tag. The processor issues one word-wide request at a time and holds it until the cache answers with a one-cycle ready pulse. A hit flag comes with that pulse. A read that misses fetches the whole block from memory in a single transfer and installs it. Every write goes straight to memory.

Writes never allocate a line. A static mode input decides what a write hit does to the cached copy. With `wr_inval_mode` at 0 the new word is merged into the line, which stays valid. With `wr_inval_mode` at 1 the line's valid bit is cleared instead.

The controller has four states. `ST_IDLE` waits for a request. `ST_REFILL` holds a block read on the memory port. `ST_WRITE` holds a word write on the memory port. `ST_DONE` gives the one-cycle answer to the processor. The transitions are named as follows:

| Transition | From | To | Condition |
|---|---|---|---|
| T_RD_HIT | `ST_IDLE` | `ST_DONE` | read request whose tag matches a valid line |
| T_RD_MISS | `ST_IDLE` | `ST_REFILL` | read request that does not hit |
| T_WR | `ST_IDLE` | `ST_WRITE` | any write request |
| T_FILL | `ST_REFILL` | `ST_DONE` | memory ready |
| T_WACK | `ST_WRITE` | `ST_DONE` | memory ready |
| T_ACK | `ST_DONE` | `ST_IDLE` | always |

Top module: `dmwt_cache`

## Requirements
- R1: Reset clears every valid bit and leaves `cpu_ready` and `mem_req` low. The first access to each line after reset is a miss.
- R2: The byte address is decoded as follows. Bits [2:0] are the offset within the block, and bit 2 selects the word: word 0 is block bits [31:0] and word 1 is block bits [63:32]. Bits [4:3] are the line index. Bits [15:5] are the tag.
- R3: Every write is sent to memory, hit or miss. The memory port carries `mem_we`=1, the processor's address unchanged and its data. `cpu_ready` follows one cycle after the memory handshake.
- R4: A write miss leaves the valid bits and tags unchanged. A later read of that address still misses unless the line is filled by a read.
- R5: With `wr_inval_mode`=0, a write hit stores the word into the line and the line stays valid. A following read of that address hits and returns the new word.
- R6: With `wr_inval_mode`=1, a write hit clears the line's valid bit. A following read of any address in that block misses and refills.
- R7: A read miss makes exactly one memory read, at the block-aligned address (bits [2:0] zero). It installs the returned block with the new tag and sets the line valid. `cpu_ready` comes one cycle after the handshake, with `cpu_hit`=0 and the requested word of the new block.
- R8: A read hit raises `cpu_ready` and `cpu_hit` on the first clock edge after the request is taken. It makes no memory request and returns the cached word.
- R9: `cpu_hit` is high only while `cpu_ready` is high. Once `mem_req` is raised, it stays high with a stable address and direction until `mem_ready`.
- R10: A read miss to a line that holds a different tag replaces that line. The old block then misses on its next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| wr_inval_mode | input | 1 | write-hit policy: 0 update line, 1 invalidate line (static) |
| cpu_req | input | 1 | processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | ADDR_W (16) | byte address |
| cpu_wdata | input | 32 | write word |
| cpu_rdata | output | 32 | read word, valid with `cpu_ready` on reads |
| cpu_ready | output | 1 | one-cycle completion pulse |
| cpu_hit | output | 1 | request hit the cache, valid with `cpu_ready` |
| mem_req | output | 1 | memory request |
| mem_we | output | 1 | 1 word write, 0 block read |
| mem_addr | output | ADDR_W (16) | memory byte address |
| mem_wdata | output | 32 | memory write word |
| mem_rdata | input | 64 | refill block, valid with `mem_ready` |
| mem_ready | input | 1 | memory completes the current request |

## Verification
The bench drives each request just after a falling edge and counts rising edges until `cpu_ready`. Read hits must answer at the first edge (latency 1). Misses and writes answer one edge after the memory handshake, and the memory model varies its delay from 0 to 2 cycles per request. Hit flag and read data are sampled one time unit after the ready edge. The memory counters and the last read and write addresses are compared at that moment, because the handshake edge that updates them always falls before it. A reference model of valid bits, tags and memory words is stepped once per completed access. It is run in both write-hit modes over a directed sequence and a few hundred pseudo-random accesses confined to eight tags.

// File: rtl/dmwt_pkg.sv
package dmwt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REFILL = 2'd1,
        ST_WRITE  = 2'd2,
        ST_DONE   = 2'd3
    } dmwt_state_t;
endpackage

// File: rtl/dmwt_tag_store.sv
module dmwt_tag_store #(
    parameter int LINES = 4,
    parameter int IDX_W = 2,
    parameter int TAG_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [LINES-1:0] valid_vec
);
    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[i] <= 1'b0;
                tag_q[i]   <= '0;
            end else if (set_en && set_idx == IDX_W'(i)) begin
                valid_q[i] <= 1'b1;
                tag_q[i]   <= set_tag;
            end else if (clr_en && clr_idx == IDX_W'(i)) begin
                valid_q[i] <= 1'b0;
            end
        end
    end

    assign lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign valid_vec = valid_q;

    // R1: one cycle of reset leaves every line invalid
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> valid_vec == '0);
endmodule

// File: rtl/dmwt_data_store.sv
module dmwt_data_store #(
    parameter int LINES   = 4,
    parameter int IDX_W   = 2,
    parameter int WORDS   = 2,
    parameter int WSEL_W  = 1,
    parameter int WORD_W  = 32,
    parameter int BLOCK_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [BLOCK_W-1:0] fill_data,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WSEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [WSEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0]  rd_data
);
    logic [BLOCK_W-1:0] line_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                line_q[i] <= '0;
            end else if (fill_en && fill_idx == IDX_W'(i)) begin
                line_q[i] <= fill_data;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                line_q[i][wr_sel*WORD_W +: WORD_W] <= wr_data;
            end
        end
    end

    assign rd_data = line_q[rd_idx][rd_sel*WORD_W +: WORD_W];

    // R7: a refill and a word merge never hit the store in one cycle
    p_one_store_write_r7: assert property (@(posedge clk) disable iff (rst)
        !(fill_en && wr_en));

    localparam int CHECK_WORDS = WORDS;
    initial begin
        assert (CHECK_WORDS * WORD_W == BLOCK_W);
    end
endmodule

// File: rtl/dmwt_cache.sv
module dmwt_cache
    import dmwt_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int WORD_BYTES  = 4,
    parameter int BLOCK_BYTES = 8,
    parameter int LINES       = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_inval_mode,
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [8*WORD_BYTES-1:0]     cpu_wdata,
    output logic [8*WORD_BYTES-1:0]     cpu_rdata,
    output logic                        cpu_ready,
    output logic                        cpu_hit,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [8*WORD_BYTES-1:0]     mem_wdata,
    input  logic [8*BLOCK_BYTES-1:0]    mem_rdata,
    input  logic                        mem_ready
);
    localparam int WORD_W  = 8 * WORD_BYTES;
    localparam int BLOCK_W = 8 * BLOCK_BYTES;
    localparam int WORDS   = BLOCK_BYTES / WORD_BYTES;
    localparam int BOFF_W  = $clog2(WORD_BYTES);
    localparam int OFF_W   = $clog2(BLOCK_BYTES);
    localparam int IDX_W   = $clog2(LINES);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int WSEL_W  = (WORDS > 1) ? $clog2(WORDS) : 1;

    dmwt_state_t state, state_nx;

    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [WORD_W-1:0] wdata_q;
    logic              hit_q;

    logic              idle_take;
    logic [IDX_W-1:0]  lk_idx, idx_q;
    logic [TAG_W-1:0]  lk_tag, tag_q;
    logic [WSEL_W-1:0] sel_q;
    logic              lk_hit;
    logic [LINES-1:0]  valid_vec;
    logic              fill_en, wr_en, clr_en;
    logic [WORD_W-1:0] rd_word;

    assign idx_q  = addr_q[OFF_W +: IDX_W];
    assign tag_q  = addr_q[ADDR_W-1 -: TAG_W];
    assign sel_q  = addr_q[BOFF_W +: WSEL_W];
    assign lk_idx = (state == ST_IDLE) ? cpu_addr[OFF_W +: IDX_W] : idx_q;
    assign lk_tag = (state == ST_IDLE) ? cpu_addr[ADDR_W-1 -: TAG_W] : tag_q;
    assign idle_take = (state == ST_IDLE) && cpu_req;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            hit_q   <= 1'b0;
        end else if (idle_take) begin
            addr_q  <= cpu_addr;
            we_q    <= cpu_we;
            wdata_q <= cpu_wdata;
            hit_q   <= lk_hit;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we)      state_nx = ST_WRITE;   // T_WR
                    else if (lk_hit) state_nx = ST_DONE;    // T_RD_HIT
                    else             state_nx = ST_REFILL;  // T_RD_MISS
                end
            end
            ST_REFILL: if (mem_ready) state_nx = ST_DONE;   // T_FILL
            ST_WRITE:  if (mem_ready) state_nx = ST_DONE;   // T_WACK
            ST_DONE:   state_nx = ST_IDLE;                  // T_ACK
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        cpu_ready = 1'b0;
        cpu_hit   = 1'b0;
        cpu_rdata = '0;
        fill_en   = 1'b0;
        wr_en     = 1'b0;
        clr_en    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_REFILL: begin
                mem_req  = 1'b1;
                mem_addr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                fill_en  = mem_ready;
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = addr_q;
                mem_wdata = wdata_q;
                wr_en     = mem_ready && hit_q && !wr_inval_mode;
                clr_en    = mem_ready && hit_q && wr_inval_mode;
            end
            ST_DONE: begin
                cpu_ready = 1'b1;
                cpu_hit   = hit_q;
                cpu_rdata = we_q ? '0 : rd_word;
            end
        endcase
    end

    dmwt_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
        .set_en(fill_en), .set_idx(idx_q), .set_tag(tag_q),
        .clr_en(clr_en), .clr_idx(idx_q),
        .valid_vec(valid_vec)
    );

    dmwt_data_store #(.LINES(LINES), .IDX_W(IDX_W), .WORDS(WORDS), .WSEL_W(WSEL_W),
                      .WORD_W(WORD_W), .BLOCK_W(BLOCK_W)) u_data (
        .clk(clk), .rst(rst),
        .fill_en(fill_en), .fill_idx(idx_q), .fill_data(mem_rdata),
        .wr_en(wr_en), .wr_idx(idx_q), .wr_sel(sel_q), .wr_data(wdata_q),
        .rd_idx(idx_q), .rd_sel(sel_q), .rd_data(rd_word)
    );

    // R9: the hit flag never appears without the ready pulse
    p_hit_with_ready_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_hit |-> cpu_ready);
    // R9: a memory request holds its address and direction until accepted
    p_mem_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R3: a write answer is always preceded by a memory write handshake
    p_write_through_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_we) |-> $past(mem_req && mem_we && mem_ready));
    // R4: a write miss leaves the valid bits untouched
    p_wmiss_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE && mem_ready && !hit_q) |=> $stable(valid_vec));
    // R5: an update-mode write hit keeps the line valid
    p_update_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE && mem_ready && hit_q && !wr_inval_mode) |=> valid_vec[idx_q]);
    // R6: an invalidate-mode write hit drops the line
    p_inval_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE && mem_ready && hit_q && wr_inval_mode) |=> !valid_vec[idx_q]);
    // R7: after a refill the requested address hits
    p_fill_hits_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REFILL && mem_ready) |=> lk_hit);
    // R8: a read hit answers without touching memory
    p_hit_no_mem_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_hit && !cpu_we) |-> !$past(mem_req));
endmodule

// File: tb/dmwt_cache_test.sv
module dmwt_cache_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_inval_mode = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready, cpu_hit;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmwt_cache uut (
        .clk(clk), .rst(rst), .wr_inval_mode(wr_inval_mode),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    int total = 0;
    int bad = 0;

    // backing memory: 64 words covering byte addresses 0..255
    logic [31:0] bmem [64];
    int rd_cnt = 0, wr_cnt = 0, wait_cnt = 0;
    logic [15:0] last_raddr = '0, last_waddr = '0;
    logic [31:0] last_wdata = '0;

    // reference model
    logic [31:0] mdl [64];
    logic        rv [4];
    logic [10:0] rt [4];

    function automatic logic [31:0] init_word(int i);
        return 32'h1000_0000 + 32'(i) * 32'h0101_0011;
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) begin
            bmem[i] = init_word(i);
            mdl[i]  = init_word(i);
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            mem_ready <= 1'b0;
            wait_cnt  <= 0;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
            wait_cnt  <= 0;
            if (mem_we) begin
                bmem[mem_addr[7:2]] <= mem_wdata;
                wr_cnt     <= wr_cnt + 1;
                last_waddr <= mem_addr;
                last_wdata <= mem_wdata;
            end else begin
                rd_cnt     <= rd_cnt + 1;
                last_raddr <= mem_addr;
            end
        end else if (mem_req) begin
            if (wait_cnt >= (rd_cnt + wr_cnt) % 3) begin
                mem_ready <= 1'b1;
                mem_rdata <= {bmem[{mem_addr[7:3], 1'b1}], bmem[{mem_addr[7:3], 1'b0}]};
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst = 1'b1;
        wr_inval_mode = mode;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) rv[i] = 1'b0;
    endtask

    task automatic access(input string lbl, input logic we, input logic [15:0] a,
                          input logic [31:0] d);
        logic [1:0]  idx = a[4:3];
        logic [10:0] tg  = a[15:5];
        logic [5:0]  wi  = a[7:2];
        logic        exp_hit = rv[idx] && (rt[idx] == tg);
        int rd0 = rd_cnt, wr0 = wr_cnt, cyc = 0;
        logic        got_hit;
        logic [31:0] got_data;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        do begin
            @(posedge clk); #1; cyc++;
        end while (!cpu_ready && cyc < 60);
        got_hit  = cpu_hit;
        got_data = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
        if (cyc >= 60) begin
            total++; bad++;
            $display("FAIL %s R9 no ready actual=%0d expected<60", lbl, cyc);
        end
        chk({lbl, " hit"}, 64'(got_hit), 64'(exp_hit));
        if (we) begin
            chk("R3 write count", 64'(wr_cnt), 64'(wr0 + 1));
            chk("R3 write addr", 64'(last_waddr), 64'(a));
            chk("R3 write data", 64'(last_wdata), 64'(d));
            chk("R3 no read on write", 64'(rd_cnt), 64'(rd0));
            mdl[wi] = d;
            if (exp_hit && wr_inval_mode) rv[idx] = 1'b0;
        end else begin
            chk({lbl, " R2 data"}, 64'(got_data), 64'(mdl[wi]));
            if (exp_hit) begin
                chk("R8 no mem read on hit", 64'(rd_cnt), 64'(rd0));
                chk("R8 hit latency", 64'(cyc), 64'd1);
            end else begin
                chk("R7 one mem read", 64'(rd_cnt), 64'(rd0 + 1));
                chk("R7 aligned addr", 64'(last_raddr), 64'({a[15:3], 3'b000}));
                rv[idx] = 1'b1;
                rt[idx] = tg;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    logic [15:0] lfsr;
    logic [15:0] prev_a;

    initial begin
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            chk("R1 ready idle", 64'(cpu_ready), 64'd0);
            chk("R1 mem idle", 64'(mem_req), 64'd0);
            for (int l = 0; l < 4; l++) access("R1 first access", 1'b0, 16'(l * 8), 32'h0);

            do_reset(m[0]);
            // classic short sequence, reads then writes then reads
            access("R7 seq", 1'b0, 16'd0, 0);
            access("R7 seq", 1'b0, 16'd16, 0);
            access("R10 seq", 1'b0, 16'd48, 0);
            access("R7 seq", 1'b0, 16'd8, 0);
            access("R7 seq", 1'b0, 16'd56, 0);
            access("R10 seq", 1'b0, 16'd16, 0);
            access("R8 seq", 1'b0, 16'd8, 0);
            access(m ? "R6 seq" : "R5 seq", 1'b1, 16'd56, 32'hCAFE_0038);
            access("R4 seq", 1'b1, 16'd32, 32'hBEEF_0020);
            access("R4 seq", 1'b0, 16'd0, 0);
            access(m ? "R6 seq" : "R5 seq", 1'b0, 16'd60, 0);
            access(m ? "R6 seq" : "R5 seq", 1'b0, 16'd56, 0);
            access("R4 seq", 1'b0, 16'd32, 0);

            // address split: other word of the same block, then a conflicting tag
            access("R2 split", 1'b0, 16'h0048, 0);
            access("R2 split", 1'b0, 16'h004C, 0);
            access("R10 split", 1'b0, 16'h0068, 0);
            access("R10 split", 1'b0, 16'h0048, 0);

            // pseudo-random sweep over eight tags
            lfsr = 16'hACE1 ^ 16'(m);
            prev_a = 16'h0;
            for (int n = 0; n < 300; n++) begin
                logic [15:0] a;
                logic        w;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                a = (lfsr[3:0] < 4'd6) ? prev_a : {8'h00, lfsr[11:6], 2'b00};
                w = (lfsr[15:14] == 2'b00);
                access(w ? "R3 sweep" : "R7 sweep", w, a, {lfsr, 16'(n)});
                prev_a = a;
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule